// File: doc/BRIEF.md
# Conditional Block State Tracker

This block holds the 8-bit execution state that governs a short run of up to four conditionally executed instructions following a block-start instruction. When the block-start instruction retires, the pipeline presents its 8-bit state value on a load input. From then on, each instruction of the run that retires advances the state once, whether it executed or was skipped. On stall cycles, when nothing retires, the state is held.

The upper three bits carry the base condition. The lower five bits carry the per-instruction condition bits together with a trailing length marker. A left shift of the low five bits therefore moves the next instruction's condition bit into place and consumes one slot of the run. From the current state the block reports whether the present instruction lies inside a run, whether it is the final one, and its 4-bit condition. It also tests that condition against the N, Z, C and V flags to give an execute or skip decision.

A synchronous clear input drops the state back to normal execution. It is meant for flushes and exception entry.

Top module: `cblk_tracker`

## Requirements
- R1: After an asynchronous reset `state_o` is 0x00, `in_blk_o` and `last_o` are 0, `cond_o` is 4'b1110 and `exec_o` is 1.
- R2: When `load_i` is high and `clr_i` is low, `state_o` equals `load_val_i` one clock later, even if `retire_i` is also high.
- R3: When `clr_i` is high, `state_o` is 0x00 one clock later, regardless of `load_i` and `retire_i`.
- R4: When `retire_i` is high, `clr_i` and `load_i` are low, and `state_o[2:0]` is nonzero, the next `state_o[7:5]` is unchanged and the next `state_o[4:0]` is the old `state_o[3:0]` followed by a 0 in bit 0.
- R5: When `retire_i` is high, `clr_i` and `load_i` are low, and `state_o[2:0]` is 000, the next `state_o` is 0x00.
- R6: When `clr_i`, `load_i` and `retire_i` are all low, `state_o` keeps its value.
- R7: `in_blk_o` is 1 exactly when `state_o[3:0]` is not 0000.
- R8: `last_o` is 1 exactly when `state_o[3:0]` is 1000, and one retire after `last_o` the tracker is outside a run.
- R9: `cond_o` equals `state_o[7:4]` inside a run and 4'b1110 outside one.
- R10: Inside a run, `exec_o` follows the condition table, with `flags_i` = {N,Z,C,V} (bit 3 = N, bit 0 = V). The entries are: 0000 Z, 0001 !Z, 0010 C, 0011 !C, 0100 N, 0101 !N, 0110 V, 0111 !V, 1000 C&!Z, 1001 !C|Z, 1010 N==V, 1011 N!=V, 1100 !Z&(N==V), 1101 Z|(N!=V).
- R11: `exec_o` is 1 for conditions 1110 and 1111 and whenever the tracker is outside a run.
- R12: After a load, the run lasts the number of retires set by the lowest set bit of `load_val_i[4:0]`: bit 0 gives 4, bit 1 gives 3, bit 2 gives 2, bit 3 gives 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear to normal execution |
| load_i | input | 1 | Load state from a retiring block-start instruction |
| load_val_i | input | 8 | State value to load |
| retire_i | input | 1 | An instruction of the run retired this cycle |
| flags_i | input | 4 | Condition flags {N,Z,C,V} |
| state_o | output | 8 | Current execution state |
| in_blk_o | output | 1 | Current instruction is inside a run |
| last_o | output | 1 | Current instruction is the last of its run |
| cond_o | output | 4 | Condition of the current instruction |
| exec_o | output | 1 | 1 = execute, 0 = skip |

## Verification
The decode outputs are combinational from the state register, so a corrupted state bit appears on `cond_o`, `in_blk_o` or `last_o` in the same cycle it is stored. A faulty shift shows as a wrong condition at the next retire. It can also show as a run that ends early or late, which appears at the ports no more than four retires after the load. Condition-table faults show on `exec_o` as soon as the matching flag pattern is applied. For that reason every condition is held inside a one-instruction run while all sixteen flag patterns are applied.

// File: rtl/cblk_pkg.sv
package cblk_pkg;
  localparam int unsigned STATE_W = 8;
  localparam int unsigned COND_W  = 4;
  localparam int unsigned BASE_W  = 3;
  localparam int unsigned MASK_W  = STATE_W - BASE_W;
  localparam int unsigned TAIL_W  = MASK_W - 2;
  localparam int unsigned FLAG_W  = 4;

  localparam logic [COND_W-1:0] COND_ALWAYS = 4'b1110;

  typedef enum logic [2:0] {
    PRED_ZERO   = 3'b000,
    PRED_CARRY  = 3'b001,
    PRED_NEG    = 3'b010,
    PRED_OVF    = 3'b011,
    PRED_HIGHER = 3'b100,
    PRED_GE     = 3'b101,
    PRED_GT     = 3'b110,
    PRED_ANY    = 3'b111
  } pred_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/cblk_state_next.sv
module cblk_state_next
  import cblk_pkg::*;
(
  input  logic [STATE_W-1:0] cur_i,
  input  logic               clr_i,
  input  logic               load_i,
  input  logic [STATE_W-1:0] load_val_i,
  input  logic               retire_i,
  output logic [STATE_W-1:0] nxt_o,
  output logic               en_o
);
  logic               tail_empty;
  logic [STATE_W-1:0] shifted;

  assign tail_empty = (cur_i[TAIL_W-1:0] == '0);
  assign shifted    = {cur_i[STATE_W-1:MASK_W], cur_i[MASK_W-2:0], 1'b0};

  always_comb begin
    en_o  = clr_i | load_i | retire_i;
    nxt_o = cur_i;
    if (clr_i) begin
      nxt_o = '0;
    end else if (load_i) begin
      nxt_o = load_val_i;
    end else if (retire_i) begin
      nxt_o = tail_empty ? '0 : shifted;
    end
  end
endmodule

// File: rtl/cblk_decode.sv
module cblk_decode
  import cblk_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  output logic               in_blk_o,
  output logic               last_o,
  output logic [COND_W-1:0]  cond_o
);
  localparam logic [COND_W-1:0] LAST_PAT = {1'b1, {(COND_W-1){1'b0}}};

  logic [COND_W-1:0] low;

  assign low = state_i[COND_W-1:0];

  always_comb begin
    in_blk_o = (low != '0);
    last_o   = (low == LAST_PAT);
    cond_o   = in_blk_o ? state_i[STATE_W-1:STATE_W-COND_W] : COND_ALWAYS;
  end
endmodule

// File: rtl/cblk_cond_eval.sv
module cblk_cond_eval
  import cblk_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              in_blk_i,
  output logic              exec_o
);
  flags_t f;
  pred_e  sel;
  logic   base;
  logic   invert;

  assign f   = flags_t'(flags_i);
  assign sel = pred_e'(cond_i[COND_W-1:1]);

  always_comb begin
    unique case (sel)
      PRED_ZERO:   base = f.z;
      PRED_CARRY:  base = f.c;
      PRED_NEG:    base = f.n;
      PRED_OVF:    base = f.v;
      PRED_HIGHER: base = f.c & ~f.z;
      PRED_GE:     base = ~(f.n ^ f.v);
      PRED_GT:     base = ~f.z & ~(f.n ^ f.v);
      default:     base = 1'b1;
    endcase
    invert = cond_i[0] & (sel != PRED_ANY);
    exec_o = ~in_blk_i | (base ^ invert);
  end
endmodule

// File: rtl/cblk_tracker.sv
module cblk_tracker
  import cblk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               load_i,
  input  logic [STATE_W-1:0] load_val_i,
  input  logic               retire_i,
  input  logic [FLAG_W-1:0]  flags_i,
  output logic [STATE_W-1:0] state_o,
  output logic               in_blk_o,
  output logic               last_o,
  output logic [COND_W-1:0]  cond_o,
  output logic               exec_o
);
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_d;
  logic               state_en;

  cblk_state_next u_next (
    .cur_i      (state_q),
    .clr_i      (clr_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .retire_i   (retire_i),
    .nxt_o      (state_d),
    .en_o       (state_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  cblk_decode u_dec (
    .state_i  (state_q),
    .in_blk_o (in_blk_o),
    .last_o   (last_o),
    .cond_o   (cond_o)
  );

  cblk_cond_eval u_eval (
    .cond_i   (cond_o),
    .flags_i  (flags_i),
    .in_blk_i (in_blk_o),
    .exec_o   (exec_o)
  );

  assign state_o = state_q;
endmodule

// File: rtl/cblk_tracker_chk.sv
module cblk_tracker_chk
  import cblk_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               clr_i,
  input logic               load_i,
  input logic [STATE_W-1:0] load_val_i,
  input logic               retire_i,
  input logic [FLAG_W-1:0]  flags_i,
  input logic [STATE_W-1:0] state_o,
  input logic               in_blk_o,
  input logic               last_o,
  input logic [COND_W-1:0]  cond_o,
  input logic               exec_o
);
  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (state_o == '0));

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && load_i) |=> (state_o == $past(load_val_i)));

  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !load_i && !retire_i) |=> $stable(state_o));

  assert_shift_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !load_i && retire_i && state_o[2:0] != 3'b000) |=>
      (state_o[7:5] == $past(state_o[7:5]) && state_o[4:0] == {$past(state_o[3:0]), 1'b0}));

  assert_tail_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !load_i && retire_i && state_o[2:0] == 3'b000) |=> (state_o == '0));

  assert_last_exits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !clr_i && !load_i && retire_i) |=> !in_blk_o);

  assert_last_inside_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> in_blk_o);

  assert_outside_runs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_blk_o |-> (exec_o && cond_o == COND_ALWAYS));

  assert_eq_uses_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_blk_o && cond_o == 4'b0000) |-> (exec_o == flags_i[2]));
endmodule

bind cblk_tracker cblk_tracker_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_i      (clr_i),
  .load_i     (load_i),
  .load_val_i (load_val_i),
  .retire_i   (retire_i),
  .flags_i    (flags_i),
  .state_o    (state_o),
  .in_blk_o   (in_blk_o),
  .last_o     (last_o),
  .cond_o     (cond_o),
  .exec_o     (exec_o)
);

// File: tb/sim_cblk_tracker.sv
`timescale 1ns/1ps
module sim_cblk_tracker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_i = 1'b0;
  logic       load_i = 1'b0;
  logic [7:0] load_val_i = 8'h00;
  logic       retire_i = 1'b0;
  logic [3:0] flags_i = 4'h0;
  logic [7:0] state_o;
  logic       in_blk_o;
  logic       last_o;
  logic [3:0] cond_o;
  logic       exec_o;

  int nvec = 0;
  int nerr = 0;
  logic [7:0] ms = 8'h00;

  always #2.5 clk = ~clk;

  cblk_tracker u0 (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .load_i(load_i),
    .load_val_i(load_val_i), .retire_i(retire_i), .flags_i(flags_i),
    .state_o(state_o), .in_blk_o(in_blk_o), .last_o(last_o),
    .cond_o(cond_o), .exec_o(exec_o)
  );

  function automatic logic [7:0] m_next(logic [7:0] s, logic c, logic l,
                                        logic [7:0] v, logic r);
    if (c) return 8'h00;
    if (l) return v;
    if (r) begin
      if (s[2:0] == 3'b000) return 8'h00;
      return {s[7:5], s[3:0], 1'b0};
    end
    return s;
  endfunction

  function automatic logic m_exec(logic [3:0] c, logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'h0: return z;
      4'h1: return !z;
      4'h2: return cy;
      4'h3: return !cy;
      4'h4: return n;
      4'h5: return !n;
      4'h6: return v;
      4'h7: return !v;
      4'h8: return cy && !z;
      4'h9: return !cy || z;
      4'hA: return n == v;
      4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(string tag);
    logic ein, elast, eex;
    logic [3:0] econd;
    ein   = (ms[3:0] != 4'h0);
    elast = (ms[3:0] == 4'h8);
    econd = ein ? ms[7:4] : 4'hE;
    eex   = ein ? m_exec(ms[7:4], flags_i) : 1'b1;
    nvec++;
    if (state_o !== ms || in_blk_o !== ein || last_o !== elast ||
        cond_o !== econd || exec_o !== eex) begin
      nerr++;
      $display("FAIL %s: got state=%h in=%b last=%b cond=%h exec=%b exp state=%h in=%b last=%b cond=%h exec=%b",
               tag, state_o, in_blk_o, last_o, cond_o, exec_o, ms, ein, elast, econd, eex);
    end
  endtask

  task automatic apply(logic c, logic l, logic [7:0] v, logic r);
    clr_i = c; load_i = l; load_val_i = v; retire_i = r;
    ms = m_next(ms, c, l, v, r);
    @(negedge clk);
    clr_i = 1'b0; load_i = 1'b0; load_val_i = 8'h00; retire_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset");
  endtask

  task automatic t_priority();
    apply(1'b0, 1'b1, 8'hAD, 1'b0);
    chk("R2 load");
    apply(1'b0, 1'b1, 8'h5A, 1'b1);
    chk("R2 load over retire");
    apply(1'b1, 1'b1, 8'hC4, 1'b1);
    chk("R3 clear over load");
    apply(1'b0, 1'b1, 8'h78, 1'b0);
    apply(1'b1, 1'b0, 8'h00, 1'b1);
    chk("R3 clear in run");
  endtask

  task automatic t_length(logic [7:0] v, int exp_len);
    int n = 0;
    apply(1'b0, 1'b1, v, 1'b0);
    chk("R7/R9 after load");
    for (int i = 0; i < 6 && in_blk_o; i++) begin
      apply(1'b0, 1'b0, 8'h00, 1'b1);
      n++;
      chk("R4/R5/R8 advance");
    end
    nvec++;
    if (n != exp_len) begin
      nerr++;
      $display("FAIL R12 length for %h: got %0d exp %0d", v, n, exp_len);
    end
  endtask

  task automatic t_stall();
    apply(1'b0, 1'b1, 8'hAD, 1'b0);
    apply(1'b0, 1'b0, 8'h00, 1'b1);
    for (int i = 0; i < 5; i++) begin
      flags_i = 4'(i * 3);
      apply(1'b0, 1'b0, 8'h00, 1'b0);
      chk("R6 hold");
    end
    apply(1'b1, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic t_cond_table();
    for (int c = 0; c < 16; c++) begin
      apply(1'b0, 1'b1, {4'(c), 4'b1000}, 1'b0);
      for (int f = 0; f < 16; f++) begin
        @(negedge clk);
        flags_i = 4'(f);
        #1;
        chk((c >= 14) ? "R11 always" : "R10 cond table");
      end
    end
    apply(1'b0, 1'b0, 8'h00, 1'b1);
    chk("R8 last exits");
  endtask

  task automatic t_outside();
    for (int f = 0; f < 16; f++) begin
      @(negedge clk);
      flags_i = 4'(f);
      #1;
      chk("R11 outside run");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_priority();
    t_length(8'hAD, 4);
    t_length(8'h5A, 3);
    t_length(8'hC4, 2);
    t_length(8'h78, 1);
    t_length(8'h03, 4);
    t_stall();
    t_cond_table();
    t_outside();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #1000000;
    nerr++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule